// File: doc/BRIEF.md
# Read Data Delay Window Calibrator

This block trains the input delay taps used to capture read data from a DRAM. After a start pulse it sends an activate command, then a single write of a fixed pseudo-random pattern spread over every phase of the data bus. It then works through the data lanes one at a time. For each lane it reads the pattern back while stepping that lane's delay tap upward. It records the first tap that reads back correctly and the first tap above it that fails, and it leaves the tap at the midpoint of that window. When every lane is done it closes the row with a precharge and raises done.

Every command targets bank 0, address 0, so the block has no address or bank outputs. The delay elements and the memory sit outside the block. The tap controls are a one-hot lane select with single-cycle reset and increment pulses. The results are a per-lane minimum, maximum and error flag.

Top module: `rdly_calib`

## Requirements
- R1: While reset is asserted and afterwards until start, busy and done are low, cmd_cs, tap_rst and tap_inc are low, and tap_sel is zero.
- R2: The pattern is built from a state that starts at 42 and is stepped by next = 1664525*state + 1013904223 (mod 2^32). Pattern byte k takes the low byte of the state after k+1 steps. Byte k sits at cmd_wdata bits [8k+7:8k], with k = phase*DBYTES + byte.
- R3: Every command lasts one cycle. The first command is an activate (cs, ras). The second is the write (cs, cas, we, wrdata). Then come only reads (cs, cas, rddata). The last is a precharge (cs, ras, we).
- R4: Lanes are handled in order i = 0 upward. While lane i is handled, tap_sel equals 1 << (DBYTES/2 - 1 - i). Otherwise tap_sel is zero.
- R5: Lane i passes only if, in every phase, both byte i and byte i + DBYTES/2 of rd_data equal the pattern.
- R6: The minimum is the first tap from reset that passes. The maximum is the first tap above the minimum that fails, or LIMIT if no tap below LIMIT fails.
- R7: A lane without error ends with a tap_rst pulse followed by exactly (min+max)/2 tap_inc pulses.
- R8: If no tap below LIMIT passes, the lane's error flag is set and its minimum and maximum both read LIMIT. Its tap is left at reset, with zero increments.
- R9: tap_rst and tap_inc never fall in the same cycle. At most LIMIT-1 increments follow any tap_rst.
- R10: rd_data is judged WAIT cycles after the read command, so consecutive reads are at least WAIT+2 cycles apart.
- R11: done rises after the precharge and stays high until the next start. busy is high from start until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin calibration (taken when idle or done) |
| rd_data | input | NPHASES*DBYTES*8 | Data returned by a read, all phases |
| cmd_cs | output | 1 | Command strobe, one cycle per command |
| cmd_ras | output | 1 | Row strobe bit of the command |
| cmd_cas | output | 1 | Column strobe bit of the command |
| cmd_we | output | 1 | Write-enable bit of the command |
| cmd_wrdata | output | 1 | Command carries write data |
| cmd_rddata | output | 1 | Command returns read data |
| cmd_wdata | output | NPHASES*DBYTES*8 | Pattern driven as write data |
| tap_sel | output | DBYTES/2 | One-hot lane select for the tap controls |
| tap_rst | output | 1 | Reset the selected tap to zero |
| tap_inc | output | 1 | Step the selected tap by one |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration finished |
| res_min | output | DBYTES/2*$clog2(LIMIT+1) | Per-lane minimum, lane i at field i |
| res_max | output | DBYTES/2*$clog2(LIMIT+1) | Per-lane maximum, lane i at field i |
| res_err | output | DBYTES/2 | Per-lane error flag |

## Verification
A pass and the sweep limit can arrive in the same evaluation. This happens when the last tap below LIMIT reads correctly: the pass decision and the limit decision then both fall on that one result. The bench provokes it with one lane whose window opens exactly at LIMIT-1 and another whose window runs past LIMIT. In both cases it expects a maximum of LIMIT, a centred tap derived from it, and no increment beyond LIMIT-1. Other cases give a lane no window at all, or corrupt only one byte half in one phase, to confirm that both halves are judged.

// File: rtl/rdly_calib.sv
module rdly_calib #(
  parameter int NPHASES = 2,
  parameter int DBYTES  = 4,
  parameter int LIMIT   = 32,
  parameter int WAIT    = 15
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     start,
  input  logic [NPHASES*DBYTES*8-1:0]              rd_data,
  output logic                                     cmd_cs,
  output logic                                     cmd_ras,
  output logic                                     cmd_cas,
  output logic                                     cmd_we,
  output logic                                     cmd_wrdata,
  output logic                                     cmd_rddata,
  output logic [NPHASES*DBYTES*8-1:0]              cmd_wdata,
  output logic [DBYTES/2-1:0]                      tap_sel,
  output logic                                     tap_rst,
  output logic                                     tap_inc,
  output logic                                     busy,
  output logic                                     done,
  output logic [DBYTES/2*$clog2(LIMIT+1)-1:0]      res_min,
  output logic [DBYTES/2*$clog2(LIMIT+1)-1:0]      res_max,
  output logic [DBYTES/2-1:0]                      res_err
);
  localparam int HALF = DBYTES / 2;
  localparam int NB   = NPHASES * DBYTES;
  localparam int PW   = NB * 8;
  localparam int CW   = $clog2(LIMIT + 1);
  localparam int LW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int WW   = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CW-1:0]   LIM     = CW'(LIMIT);
  localparam logic [HALF-1:0] TOP_SEL = {1'b1, {(HALF-1){1'b0}}};

  function automatic logic [PW-1:0] make_pattern();
    logic [PW-1:0] r;
    logic [31:0]   s;
    r = '0;
    s = 32'd42;
    for (int k = 0; k < NB; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      r[k*8 +: 8] = s[7:0];
    end
    return r;
  endfunction

  localparam logic [PW-1:0] PAT = make_pattern();

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_AWAIT, S_WR, S_SEL, S_RD, S_RWAIT, S_EVAL,
    S_INC, S_CTR, S_CINC, S_NEXT, S_PRE, S_DONE
  } state_t;

  state_t          state;
  logic [LW-1:0]   lane;
  logic [WW-1:0]   wcnt;
  logic [CW-1:0]   delay, cur_min, cur_max, ccnt;
  logic            srch_max, cur_err, lane_ok;
  logic [CW-1:0]   nd;
  logic [CW:0]     mid;

  assign nd  = delay + 1'b1;
  assign mid = ({1'b0, cur_min} + {1'b0, cur_max}) >> 1;

  always_comb begin
    lane_ok = 1'b1;
    for (int p = 0; p < NPHASES; p++) begin
      if (rd_data[(p*DBYTES + int'(lane))*8 +: 8] != PAT[(p*DBYTES + int'(lane))*8 +: 8])
        lane_ok = 1'b0;
      if (rd_data[(p*DBYTES + int'(lane) + HALF)*8 +: 8] != PAT[(p*DBYTES + int'(lane) + HALF)*8 +: 8])
        lane_ok = 1'b0;
    end
  end

  assign cmd_cs     = (state == S_ACT) || (state == S_WR) || (state == S_RD) || (state == S_PRE);
  assign cmd_ras    = (state == S_ACT) || (state == S_PRE);
  assign cmd_cas    = (state == S_WR)  || (state == S_RD);
  assign cmd_we     = (state == S_WR)  || (state == S_PRE);
  assign cmd_wrdata = (state == S_WR);
  assign cmd_rddata = (state == S_RD);
  assign cmd_wdata  = PAT;
  assign tap_rst    = (state == S_SEL) || (state == S_CTR);
  assign tap_inc    = (state == S_INC) || (state == S_CINC);
  assign busy       = (state != S_IDLE) && (state != S_DONE);
  assign done       = (state == S_DONE);

  always_comb begin
    case (state)
      S_SEL, S_RD, S_RWAIT, S_EVAL, S_INC, S_CTR, S_CINC: tap_sel = TOP_SEL >> lane;
      default:                                            tap_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lane     <= '0;
      wcnt     <= '0;
      delay    <= '0;
      cur_min  <= '0;
      cur_max  <= '0;
      cur_err  <= 1'b0;
      ccnt     <= '0;
      srch_max <= 1'b0;
      res_min  <= '0;
      res_max  <= '0;
      res_err  <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          state   <= S_ACT;
          res_err <= '0;
          lane    <= '0;
        end
        S_ACT: begin
          wcnt  <= '0;
          state <= S_AWAIT;
        end
        S_AWAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WW'(WAIT - 1)) state <= S_WR;
        end
        S_WR: state <= S_SEL;
        S_SEL: begin
          delay    <= '0;
          srch_max <= 1'b0;
          cur_err  <= 1'b0;
          state    <= S_RD;
        end
        S_RD: begin
          wcnt  <= '0;
          state <= S_RWAIT;
        end
        S_RWAIT: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == WW'(WAIT - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (!srch_max) begin
            if (lane_ok) begin
              cur_min <= delay;
              if (nd >= LIM) begin
                cur_max <= nd;
                state   <= S_CTR;
              end else begin
                delay    <= nd;
                srch_max <= 1'b1;
                state    <= S_INC;
              end
            end else if (nd >= LIM) begin
              cur_min <= LIM;
              cur_max <= LIM;
              cur_err <= 1'b1;
              state   <= S_CTR;
            end else begin
              delay <= nd;
              state <= S_INC;
            end
          end else begin
            if (!lane_ok) begin
              cur_max <= delay;
              state   <= S_CTR;
            end else if (nd >= LIM) begin
              cur_max <= nd;
              state   <= S_CTR;
            end else begin
              delay <= nd;
              state <= S_INC;
            end
          end
        end
        S_INC: state <= S_RD;
        S_CTR: begin
          res_min[int'(lane)*CW +: CW] <= cur_min;
          res_max[int'(lane)*CW +: CW] <= cur_max;
          res_err[lane]                <= cur_err;
          ccnt <= mid[CW-1:0];
          if (cur_err || mid == '0) state <= S_NEXT;
          else                      state <= S_CINC;
        end
        S_CINC: begin
          ccnt <= ccnt - 1'b1;
          if (ccnt == CW'(1)) state <= S_NEXT;
        end
        S_NEXT: begin
          if (lane == LW'(HALF - 1)) state <= S_PRE;
          else begin
            lane  <= lane + 1'b1;
            state <= S_SEL;
          end
        end
        S_PRE:   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module rdly_calib_chk #(
  parameter int DBYTES = 4,
  parameter int LIMIT  = 32,
  parameter int WAIT   = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                cmd_cs,
  input logic                cmd_ras,
  input logic                cmd_cas,
  input logic                cmd_we,
  input logic                cmd_wrdata,
  input logic                cmd_rddata,
  input logic [DBYTES/2-1:0] tap_sel,
  input logic                tap_rst,
  input logic                tap_inc,
  input logic                busy,
  input logic                done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam int GW = $clog2(WAIT + 3) + 1;

  logic [CW-1:0] inc_cnt;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_cnt <= '0;
      gap     <= '1;
    end else begin
      if (tap_rst)      inc_cnt <= '0;
      else if (tap_inc) inc_cnt <= inc_cnt + 1'b1;
      if (cmd_rddata)              gap <= '0;
      else if (gap != '1)          gap <= gap + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (!cmd_cs && !tap_rst && !tap_inc && tap_sel == '0));
  a_r3_single_cycle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs |=> !cmd_cs);
  a_r3_read_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rddata |-> (cmd_cs && cmd_cas && !cmd_ras && !cmd_we && !cmd_wrdata));
  a_r3_write_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdata |-> (cmd_cs && cmd_cas && cmd_we && !cmd_ras && !cmd_rddata));
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tap_sel));
  a_r4_tap_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_rst || tap_inc) |-> (tap_sel != '0));
  a_r9_no_rst_inc_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_rst && tap_inc));
  a_r9_inc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tap_inc |-> (int'(inc_cnt) < LIMIT - 1));
  a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rddata |-> (int'(gap) >= WAIT + 1));
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  a_r11_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind rdly_calib rdly_calib_chk #(.DBYTES(DBYTES), .LIMIT(LIMIT), .WAIT(WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_cs(cmd_cs), .cmd_ras(cmd_ras),
  .cmd_cas(cmd_cas), .cmd_we(cmd_we), .cmd_wrdata(cmd_wrdata), .cmd_rddata(cmd_rddata),
  .tap_sel(tap_sel), .tap_rst(tap_rst), .tap_inc(tap_inc), .busy(busy), .done(done)
);

// File: tb/rdly_calib_bench.sv
module rdly_calib_bench;
  localparam int NP  = 2;
  localparam int NB  = 4;
  localparam int HF  = NB / 2;
  localparam int LIM = 32;
  localparam int WT  = 15;
  localparam int CW  = $clog2(LIM + 1);
  localparam int PW  = NP * NB * 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] rd_data, cmd_wdata, pat;
  logic cmd_cs, cmd_ras, cmd_cas, cmd_we, cmd_wrdata, cmd_rddata;
  logic [HF-1:0] tap_sel, res_err;
  logic tap_rst, tap_inc, busy, done;
  logic [HF*CW-1:0] res_min, res_max;

  always #2 clk = ~clk;

  rdly_calib #(.NPHASES(NP), .DBYTES(NB), .LIMIT(LIM), .WAIT(WT)) u_rdly_calib (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data),
    .cmd_cs(cmd_cs), .cmd_ras(cmd_ras), .cmd_cas(cmd_cas), .cmd_we(cmd_we),
    .cmd_wrdata(cmd_wrdata), .cmd_rddata(cmd_rddata), .cmd_wdata(cmd_wdata),
    .tap_sel(tap_sel), .tap_rst(tap_rst), .tap_inc(tap_inc),
    .busy(busy), .done(done), .res_min(res_min), .res_max(res_max), .res_err(res_err)
  );

  int total = 0, fails = 0;
  int lo [HF], hi [HF], mode [HF], tap_m [HF], incs [HF];
  int cyc, n_cmd, n_rd, last_rd, min_gap, max_incs, overlap, bad_cmd, busy_low;
  int kind_first, kind_second, kind_last;
  logic [HF-1:0] first_sel, last_sel;
  logic [PW-1:0] wcap;

  initial begin
    logic [31:0] s;
    s = 32'd42;
    for (int k = 0; k < NP*NB; k++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      pat[k*8 +: 8] = s[7:0];
    end
    for (int j = 0; j < HF; j++) begin
      lo[j] = 0; hi[j] = 0; mode[j] = 0; tap_m[j] = 0; incs[j] = 0;
    end
  end

  always_comb begin
    rd_data = pat;
    for (int j = 0; j < HF; j++) begin
      if (!(tap_m[j] >= lo[j] && tap_m[j] <= hi[j])) begin
        case (mode[j])
          0: for (int p = 0; p < NP; p++) begin
               rd_data[(p*NB + j)*8 +: 8]      = rd_data[(p*NB + j)*8 +: 8] ^ 8'hFF;
               rd_data[(p*NB + j + HF)*8 +: 8] = rd_data[(p*NB + j + HF)*8 +: 8] ^ 8'hFF;
             end
          1: rd_data[((NP-1)*NB + j + HF)*8 +: 8] = rd_data[((NP-1)*NB + j + HF)*8 +: 8] ^ 8'h5A;
          default: rd_data[j*8 +: 8] = rd_data[j*8 +: 8] ^ 8'h01;
        endcase
      end
    end
  end

  // kinds: 1 activate, 2 write, 3 read, 4 precharge, 9 malformed
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (tap_rst && tap_inc) overlap++;
      for (int j = 0; j < HF; j++) begin
        if (tap_sel[HF-1-j]) begin
          if (tap_rst) begin tap_m[j] = 0; incs[j] = 0; end
          if (tap_inc) begin
            tap_m[j]++; incs[j]++;
            if (incs[j] > max_incs) max_incs = incs[j];
          end
        end
      end
      if (tap_sel != '0) begin
        if (first_sel == '0) first_sel = tap_sel;
        last_sel = tap_sel;
      end
      if (n_cmd > 0 && !done && !busy) busy_low++;
      if (cmd_cs) begin
        int k;
        if (cmd_ras && !cmd_cas && !cmd_we && !cmd_wrdata && !cmd_rddata) k = 1;
        else if (!cmd_ras && cmd_cas && cmd_we && cmd_wrdata && !cmd_rddata) k = 2;
        else if (!cmd_ras && cmd_cas && !cmd_we && !cmd_wrdata && cmd_rddata) k = 3;
        else if (cmd_ras && !cmd_cas && cmd_we && !cmd_wrdata && !cmd_rddata) k = 4;
        else k = 9;
        n_cmd++;
        if (n_cmd == 1) kind_first = k;
        if (n_cmd == 2) kind_second = k;
        if (n_cmd > 2 && kind_last != 3 && kind_last != 2) bad_cmd++;
        if (n_cmd > 2 && k != 3 && k != 4) bad_cmd++;
        kind_last = k;
        if (k == 2) wcap = cmd_wdata;
        if (k == 3) begin
          if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap = cyc - last_rd;
          last_rd = cyc; n_rd++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n_cmd = 0; n_rd = 0; last_rd = -1; min_gap = 1 << 30; max_incs = 0;
    overlap = 0; bad_cmd = 0; busy_low = 0; kind_first = 0; kind_second = 0;
    kind_last = 0; first_sel = '0; last_sel = '0; wcap = '0;
  endtask

  task automatic run_and_check(input string name);
    int t;
    bit seen_busy;
    clear_log();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    seen_busy = busy;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, "R11", {name, " done reached"}, 64'(done), 1);
    chk(seen_busy && busy_low == 0, "R11", {name, " busy during run"}, 64'(busy_low), 0);
    chk(kind_first == 1 && kind_second == 2, "R3", {name, " activate then write"},
        64'(kind_first*10 + kind_second), 12);
    chk(kind_last == 4 && bad_cmd == 0, "R3", {name, " reads then precharge"},
        64'(kind_last*100 + bad_cmd), 400);
    chk(wcap == pat, "R2", {name, " write pattern"}, wcap, pat);
    chk(first_sel == HF'(1 << (HF-1)) && last_sel == HF'(1), "R4", {name, " lane select order"},
        64'({first_sel, last_sel}), 64'({HF'(1 << (HF-1)), HF'(1)}));
    chk(min_gap >= WT + 2, "R10", {name, " read spacing"}, 64'(min_gap), WT + 2);
    chk(overlap == 0 && max_incs <= LIM - 1, "R9", {name, " tap pulse bounds"},
        64'(overlap*1000 + max_incs), LIM - 1);
    for (int j = 0; j < HF; j++) begin
      int emin, emax, etap;
      bit eerr;
      eerr = (lo[j] >= LIM);
      emin = eerr ? LIM : lo[j];
      emax = eerr ? LIM : ((hi[j] + 1 < LIM) ? hi[j] + 1 : LIM);
      etap = eerr ? 0 : (emin + emax) / 2;
      chk(res_min[j*CW +: CW] == CW'(emin), eerr ? "R8" : "R6", $sformatf("%s lane %0d min", name, j),
          64'(res_min[j*CW +: CW]), 64'(emin));
      chk(res_max[j*CW +: CW] == CW'(emax), eerr ? "R8" : "R6", $sformatf("%s lane %0d max", name, j),
          64'(res_max[j*CW +: CW]), 64'(emax));
      chk(res_err[j] == eerr, "R8", $sformatf("%s lane %0d error", name, j),
          64'(res_err[j]), 64'(eerr));
      chk(tap_m[j] == etap, eerr ? "R8" : "R7", $sformatf("%s lane %0d final tap", name, j),
          64'(tap_m[j]), 64'(etap));
    end
    clear_log();
    repeat (5) @(negedge clk);
    chk(done && n_cmd == 0, "R11", {name, " done held, quiet"}, 64'({done, 8'(n_cmd)}), 64'h100);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !cmd_cs && !tap_rst && !tap_inc && tap_sel == '0, "R1", "reset state",
        64'({busy, done, cmd_cs, tap_rst, tap_inc, tap_sel}), 0);
  endtask

  task automatic t_plain_windows();
    lo[0] = 5; hi[0] = 12; mode[0] = 0;
    lo[1] = 0; hi[1] = 3;  mode[1] = 0;
    run_and_check("plain");
  endtask

  task automatic t_limit_edges();
    lo[0] = 99;      hi[0] = 99; mode[0] = 0;
    lo[1] = LIM - 1; hi[1] = 40; mode[1] = 0;
    run_and_check("limit");
  endtask

  task automatic t_half_bytes();
    lo[0] = 3; hi[0] = 6;  mode[0] = 1;
    lo[1] = 8; hi[1] = 20; mode[1] = 2;
    run_and_check("R5 halves");
  endtask

  task automatic t_wide_window();
    lo[0] = 0;  hi[0] = 60; mode[0] = 2;
    lo[1] = 17; hi[1] = 17; mode[1] = 1;
    run_and_check("R6 wide");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain_windows();
    t_limit_edges();
    t_half_bytes();
    t_wide_window();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule